// File: doc/BRIEF.md
# Task Switch Segment Validator

This block checks the code-segment and stack-segment descriptors of the task being entered during a protected-mode task switch. The caller supplies, for each of the two segments, the selector index and requested privilege, a flag saying the selector could not be resolved, and the descriptor attributes: system or code or data kind, conforming, writable, descriptor privilege and present. A single-cycle request strobe starts the check. One clock later the block returns a registered verdict: either success, or the first fault found, with its fault class and the index of the selector at fault.

The code segment is examined in full before the stack segment. The stack privilege is tied to the requested privilege of the code selector. On success the new current privilege level is reported. When the incoming task runs in virtual-8086 mode the checks are bypassed and the verdict is success.

Top module: `task_seg_checker`

## Requirements
- R1: After reset every output is zero. `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and the verdict fields change in that same cycle.
- R2: Fault class encoding is 0 none, 1 invalid-task, 2 not-present, 3 stack fault. A code selector parse failure, or a code descriptor that is a system descriptor or a data descriptor (`cs_is_code`=0), gives class 1 with `cs_index`.
- R3: For a non-conforming code descriptor, a descriptor privilege that differs from the code requested privilege gives class 1 with `cs_index`.
- R4: For a conforming code descriptor, a descriptor privilege numerically greater than the code requested privilege gives class 1 with `cs_index`. An equal or lower value passes.
- R5: A code descriptor that passes the kind and privilege checks but is not present gives class 2 with `cs_index`. A privilege fault takes precedence over absence.
- R6: Any code segment fault is reported in place of any stack segment fault.
- R7: A stack parse failure, or a stack descriptor that is system, code, or read-only data, gives class 1 with `ss_index`.
- R8: A stack descriptor privilege that differs from either the code requested privilege or the stack requested privilege gives class 1 with `ss_index`.
- R9: A stack descriptor that is not present gives class 3 with `ss_index`, but only when the stack kind and privilege checks pass.
- R10: With `vm86_mode` high, the verdict is success whatever the attributes, and `rsp_new_cpl` equals `cs_rpl`.
- R11: On success `rsp_fault_class` and `rsp_fault_index` are 0 and `rsp_new_cpl` equals `cs_rpl`. On a fault `rsp_new_cpl` is 0.
- R12: In a cycle without `req_valid`, the verdict fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a check with the present inputs |
| vm86_mode | input | 1 | Incoming task is virtual-8086; bypass checks |
| cs_index | input | 13 | Code selector index |
| cs_rpl | input | 2 | Code selector requested privilege |
| cs_parse_err | input | 1 | Code selector could not be resolved |
| cs_is_system | input | 1 | Code descriptor is a system descriptor |
| cs_is_code | input | 1 | Code descriptor is code (0 means data) |
| cs_conforming | input | 1 | Code descriptor is conforming |
| cs_dpl | input | 2 | Code descriptor privilege |
| cs_present | input | 1 | Code descriptor present |
| ss_index | input | 13 | Stack selector index |
| ss_rpl | input | 2 | Stack selector requested privilege |
| ss_parse_err | input | 1 | Stack selector could not be resolved |
| ss_is_system | input | 1 | Stack descriptor is a system descriptor |
| ss_is_code | input | 1 | Stack descriptor is code (0 means data) |
| ss_writable | input | 1 | Stack data descriptor is writable |
| ss_dpl | input | 2 | Stack descriptor privilege |
| ss_present | input | 1 | Stack descriptor present |
| rsp_valid | output | 1 | Verdict produced this cycle |
| rsp_fault_class | output | 2 | 0 none, 1 invalid-task, 2 not-present, 3 stack fault |
| rsp_fault_index | output | 13 | Selector index at fault, 0 on success |
| rsp_new_cpl | output | 2 | New current privilege level on success |

## Verification
The assertions assume that the request inputs are stable and meaningful only in the cycle when `req_valid` is high. They also assume that a system-descriptor flag overrides the code/data flag, which the block handles by testing it first. The bench drives every input at the falling edge and raises the strobe for one cycle only. It starts each scenario from a fully legal baseline and changes one or two attributes, so each fault source, and each pairing that fixes precedence, is reached on its own. Between requests the bench drives different attribute values, which shows that the held verdict ignores them.

// File: rtl/tsc_pkg.sv
// Package: shared encodings for the task switch segment validator.
// Assumes a 2-bit fault class field that the consumer decodes numerically.
package tsc_pkg;

    localparam int FAULT_W = 2;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE         = 2'd0,
        FLT_INVALID_TASK = 2'd1,
        FLT_NOT_PRESENT  = 2'd2,
        FLT_STACK        = 2'd3
    } fault_class_e;

endpackage

// File: rtl/tsc_code_check.sv
// Module: tsc_code_check
// Combinational validation of the incoming code segment descriptor.
// Assumes a system flag overrides the code/data flag. Order: kind/parse,
// then privilege, then presence; the first failure sets the class.
module tsc_code_check
    import tsc_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] dpl,
    input  logic            parse_err,
    input  logic            is_system,
    input  logic            is_code,
    input  logic            conforming,
    input  logic            present,
    output logic            fault,
    output fault_class_e    fclass
);

    logic kind_bad;
    logic priv_bad;

    // Kind check: must resolve and be a non-system code descriptor.
    always_comb begin
        kind_bad = parse_err | is_system | ~is_code;
    end

    // Privilege check: exact match unless conforming, then not above rpl.
    always_comb begin
        if (conforming) begin
            priv_bad = (dpl > rpl);
        end else begin
            priv_bad = (dpl != rpl);
        end
    end

    // Priority encode the first failing check into a fault class.
    always_comb begin
        fault  = 1'b1;
        fclass = FLT_INVALID_TASK;
        if (kind_bad || priv_bad) begin
            fclass = FLT_INVALID_TASK;
        end else if (!present) begin
            fclass = FLT_NOT_PRESENT;
        end else begin
            fault  = 1'b0;
            fclass = FLT_NONE;
        end
    end

endmodule

// File: rtl/tsc_stack_check.sv
// Module: tsc_stack_check
// Combinational validation of the incoming stack segment descriptor.
// Assumes new_cpl is the code selector's requested privilege. Order:
// kind/parse, then privilege, then presence.
module tsc_stack_check
    import tsc_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] new_cpl,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] dpl,
    input  logic            parse_err,
    input  logic            is_system,
    input  logic            is_code,
    input  logic            writable,
    input  logic            present,
    output logic            fault,
    output fault_class_e    fclass
);

    logic kind_bad;
    logic priv_bad;

    // Kind check: must resolve and be writable, non-system data.
    always_comb begin
        kind_bad = parse_err | is_system | is_code | ~writable;
    end

    // Privilege check: descriptor level matches both requested levels.
    always_comb begin
        priv_bad = (dpl != new_cpl) | (dpl != rpl);
    end

    // Priority encode the first failing check into a fault class.
    always_comb begin
        fault  = 1'b1;
        fclass = FLT_INVALID_TASK;
        if (kind_bad || priv_bad) begin
            fclass = FLT_INVALID_TASK;
        end else if (!present) begin
            fclass = FLT_STACK;
        end else begin
            fault  = 1'b0;
            fclass = FLT_NONE;
        end
    end

endmodule

// File: rtl/tsc_result_reg.sv
// Module: tsc_result_reg
// Verdict register: captures the verdict when load is high and holds it
// otherwise. Pulses the valid flag for one cycle after each load.
module tsc_result_reg
    import tsc_pkg::*;
#(
    parameter int IDX_W = 13,
    parameter int PL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  fault_class_e     fclass_in,
    input  logic [IDX_W-1:0] index_in,
    input  logic [PL_W-1:0]  cpl_in,
    output logic             valid_q,
    output fault_class_e     fclass_q,
    output logic [IDX_W-1:0] index_q,
    output logic [PL_W-1:0]  cpl_q
);

    // Valid pulse: follows the load strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
        end
    end

    // Verdict fields: captured on load, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fclass_q <= FLT_NONE;
            index_q  <= '0;
            cpl_q    <= '0;
        end else if (load) begin
            fclass_q <= fclass_in;
            index_q  <= index_in;
            cpl_q    <= cpl_in;
        end
    end

endmodule

// File: rtl/task_seg_checker.sv
// Module: task_seg_checker (top)
// Validates the code and stack descriptors of the task being entered.
// The code segment is checked first, and a code fault hides any stack fault.
// Virtual-8086 mode bypasses all checks. The verdict is registered, one cycle.
// Assumes the inputs are meaningful only while req_valid is high.
module task_seg_checker
    import tsc_pkg::*;
#(
    parameter int IDX_W = 13,
    parameter int PL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             vm86_mode,
    input  logic [IDX_W-1:0] cs_index,
    input  logic [PL_W-1:0]  cs_rpl,
    input  logic             cs_parse_err,
    input  logic             cs_is_system,
    input  logic             cs_is_code,
    input  logic             cs_conforming,
    input  logic [PL_W-1:0]  cs_dpl,
    input  logic             cs_present,
    input  logic [IDX_W-1:0] ss_index,
    input  logic [PL_W-1:0]  ss_rpl,
    input  logic             ss_parse_err,
    input  logic             ss_is_system,
    input  logic             ss_is_code,
    input  logic             ss_writable,
    input  logic [PL_W-1:0]  ss_dpl,
    input  logic             ss_present,
    output logic             rsp_valid,
    output logic [1:0]       rsp_fault_class,
    output logic [IDX_W-1:0] rsp_fault_index,
    output logic [PL_W-1:0]  rsp_new_cpl
);

    logic             code_fault;
    fault_class_e     code_class;
    logic             stack_fault;
    fault_class_e     stack_class;
    fault_class_e     sel_class;
    logic [IDX_W-1:0] sel_index;
    logic [PL_W-1:0]  sel_cpl;
    fault_class_e     fclass_q;

    tsc_code_check #(.PL_W(PL_W)) u_code (
        .rpl        (cs_rpl),
        .dpl        (cs_dpl),
        .parse_err  (cs_parse_err),
        .is_system  (cs_is_system),
        .is_code    (cs_is_code),
        .conforming (cs_conforming),
        .present    (cs_present),
        .fault      (code_fault),
        .fclass     (code_class)
    );

    tsc_stack_check #(.PL_W(PL_W)) u_stack (
        .new_cpl    (cs_rpl),
        .rpl        (ss_rpl),
        .dpl        (ss_dpl),
        .parse_err  (ss_parse_err),
        .is_system  (ss_is_system),
        .is_code    (ss_is_code),
        .writable   (ss_writable),
        .present    (ss_present),
        .fault      (stack_fault),
        .fclass     (stack_class)
    );

    // Verdict select: bypass, then code fault, then stack fault, else success.
    always_comb begin
        sel_class = FLT_NONE;
        sel_index = '0;
        sel_cpl   = cs_rpl;
        if (vm86_mode) begin
            sel_class = FLT_NONE;
        end else if (code_fault) begin
            sel_class = code_class;
            sel_index = cs_index;
            sel_cpl   = '0;
        end else if (stack_fault) begin
            sel_class = stack_class;
            sel_index = ss_index;
            sel_cpl   = '0;
        end
    end

    tsc_result_reg #(.IDX_W(IDX_W), .PL_W(PL_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (req_valid),
        .fclass_in (sel_class),
        .index_in  (sel_index),
        .cpl_in    (sel_cpl),
        .valid_q   (rsp_valid),
        .fclass_q  (fclass_q),
        .index_q   (rsp_fault_index),
        .cpl_q     (rsp_new_cpl)
    );

    // Output cast: expose the enum as a plain 2-bit field.
    always_comb begin
        rsp_fault_class = fclass_q;
    end

endmodule

// File: rtl/tsc_assert_chk.sv
// Module: tsc_assert_chk
// Property checker for task_seg_checker, attached by bind below.
// Assumes the inputs are sampled only in cycles with req_valid high.
module tsc_assert_chk #(
    parameter int IDX_W = 13,
    parameter int PL_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             vm86_mode,
    input logic [IDX_W-1:0] cs_index,
    input logic [PL_W-1:0]  cs_rpl,
    input logic             cs_parse_err,
    input logic             cs_is_system,
    input logic             cs_is_code,
    input logic             cs_conforming,
    input logic [PL_W-1:0]  cs_dpl,
    input logic [IDX_W-1:0] ss_index,
    input logic [PL_W-1:0]  ss_rpl,
    input logic             ss_present,
    input logic             rsp_valid,
    input logic [1:0]       rsp_fault_class,
    input logic [IDX_W-1:0] rsp_fault_index,
    input logic [PL_W-1:0]  rsp_new_cpl
);

    logic code_ok_nc;
    always_comb code_ok_nc = !cs_parse_err && !cs_is_system && cs_is_code;

    assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    assert_code_parse_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vm86_mode && cs_parse_err)
        |=> (rsp_fault_class == 2'd1 && rsp_fault_index == $past(cs_index)));

    assert_conforming_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vm86_mode && code_ok_nc && cs_conforming && (cs_dpl > cs_rpl))
        |=> (rsp_fault_class == 2'd1 && rsp_fault_index == $past(cs_index)));

    assert_stack_class_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_class == 2'd3) |-> (rsp_fault_index == $past(ss_index)
            && !$past(ss_present)));

    assert_bypass_success_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vm86_mode)
        |=> (rsp_fault_class == 2'd0 && rsp_new_cpl == $past(cs_rpl)));

    assert_success_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_class == 2'd0) |-> (rsp_fault_index == '0));

    assert_fault_cpl_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_class != 2'd0) |-> (rsp_new_cpl == '0));

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !$past(!rst_n)) |=> ($stable(rsp_fault_class) && $stable(rsp_fault_index)
            && $stable(rsp_new_cpl)));

    logic unused_ok;
    always_comb unused_ok = ^{ss_rpl};

endmodule

bind task_seg_checker tsc_assert_chk #(.IDX_W(IDX_W), .PL_W(PL_W)) u_chk (.*);

// File: tb/task_seg_checker_test.sv
// Bench: directed scenarios, one task each, each checking its own results.
`timescale 1ns/1ps
module task_seg_checker_test;

    localparam int IDX_W = 13;
    localparam int PL_W  = 2;
    localparam logic [IDX_W-1:0] CSI = 13'h0123;
    localparam logic [IDX_W-1:0] SSI = 13'h0456;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic vm86_mode;
    logic [IDX_W-1:0] cs_index, ss_index;
    logic [PL_W-1:0]  cs_rpl, cs_dpl, ss_rpl, ss_dpl;
    logic cs_parse_err, cs_is_system, cs_is_code, cs_conforming, cs_present;
    logic ss_parse_err, ss_is_system, ss_is_code, ss_writable, ss_present;
    logic             rsp_valid;
    logic [1:0]       rsp_fault_class;
    logic [IDX_W-1:0] rsp_fault_index;
    logic [PL_W-1:0]  rsp_new_cpl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    task_seg_checker #(.IDX_W(IDX_W), .PL_W(PL_W)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Legal baseline: both segments pass at privilege 2.
    task automatic baseline();
        vm86_mode = 0;
        cs_index = CSI; cs_rpl = 2; cs_dpl = 2; cs_parse_err = 0; cs_is_system = 0;
        cs_is_code = 1; cs_conforming = 0; cs_present = 1;
        ss_index = SSI; ss_rpl = 2; ss_dpl = 2; ss_parse_err = 0; ss_is_system = 0;
        ss_is_code = 0; ss_writable = 1; ss_present = 1;
    endtask

    // Issue one request and check the registered verdict.
    task automatic run(input string tag, input logic [1:0] ecls,
                       input logic [IDX_W-1:0] eidx, input logic [PL_W-1:0] ecpl);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " R1 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " class"}, 32'(rsp_fault_class), 32'(ecls));
        chk({tag, " index"}, 32'(rsp_fault_index), 32'(eidx));
        chk({tag, " cpl R11"}, 32'(rsp_new_cpl), 32'(ecpl));
        baseline();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset valid", 32'(rsp_valid), 0);
        chk("R1 reset class", 32'(rsp_fault_class), 0);
        chk("R1 reset index", 32'(rsp_fault_index), 0);
        chk("R1 reset cpl", 32'(rsp_new_cpl), 0);
    endtask

    task automatic t_success();
        baseline(); run("R11 ok pl2", 0, 0, 2);
        baseline(); cs_rpl = 0; cs_dpl = 0; ss_rpl = 0; ss_dpl = 0; run("R11 ok pl0", 0, 0, 0);
        baseline(); cs_rpl = 3; cs_dpl = 3; ss_rpl = 3; ss_dpl = 3; run("R11 ok pl3", 0, 0, 3);
    endtask

    task automatic t_code_kind();
        baseline(); cs_parse_err = 1; run("R2 cs parse", 1, CSI, 0);
        baseline(); cs_is_system = 1; run("R2 cs system", 1, CSI, 0);
        baseline(); cs_is_code = 0; run("R2 cs data", 1, CSI, 0);
    endtask

    task automatic t_code_priv();
        baseline(); cs_dpl = 1; run("R3 nonconf lower", 1, CSI, 0);
        baseline(); cs_dpl = 3; run("R3 nonconf higher", 1, CSI, 0);
        baseline(); cs_conforming = 1; cs_dpl = 3; run("R4 conf above", 1, CSI, 0);
        baseline(); cs_conforming = 1; cs_dpl = 0; run("R4 conf below", 0, 0, 2);
        baseline(); cs_conforming = 1; cs_dpl = 2; run("R4 conf equal", 0, 0, 2);
    endtask

    task automatic t_code_present();
        baseline(); cs_present = 0; run("R5 cs absent", 2, CSI, 0);
        baseline(); cs_present = 0; cs_dpl = 1; run("R5 priv before absent", 1, CSI, 0);
    endtask

    task automatic t_order();
        baseline(); cs_present = 0; ss_parse_err = 1; run("R6 code first np", 2, CSI, 0);
        baseline(); cs_dpl = 0; ss_present = 0; run("R6 code first ts", 1, CSI, 0);
    endtask

    task automatic t_stack_kind();
        baseline(); ss_parse_err = 1; run("R7 ss parse", 1, SSI, 0);
        baseline(); ss_is_system = 1; run("R7 ss system", 1, SSI, 0);
        baseline(); ss_is_code = 1; run("R7 ss code", 1, SSI, 0);
        baseline(); ss_writable = 0; run("R7 ss readonly", 1, SSI, 0);
    endtask

    task automatic t_stack_priv();
        baseline(); ss_dpl = 1; ss_rpl = 1; run("R8 ss vs cs rpl", 1, SSI, 0);
        baseline(); ss_rpl = 3; run("R8 ss vs own rpl", 1, SSI, 0);
    endtask

    task automatic t_stack_present();
        baseline(); ss_present = 0; run("R9 ss absent", 3, SSI, 0);
        baseline(); ss_present = 0; ss_dpl = 3; run("R9 priv before absent", 1, SSI, 0);
    endtask

    task automatic t_vm86();
        baseline(); vm86_mode = 1; cs_parse_err = 1; ss_present = 0; cs_rpl = 3;
        run("R10 bypass", 0, 0, 3);
    endtask

    // Hold: load a fault, then drive other inputs with no strobe.
    task automatic t_hold();
        baseline(); ss_present = 0; run("R12 load", 3, SSI, 0);
        cs_parse_err = 1; ss_index = 13'h1FFF; vm86_mode = 1;
        @(negedge clk);
        chk("R12 valid low", 32'(rsp_valid), 0);
        chk("R12 class held", 32'(rsp_fault_class), 3);
        chk("R12 index held", 32'(rsp_fault_index), 32'(SSI));
        baseline();
    endtask

    initial begin
        baseline();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_success();
        t_code_kind();
        t_code_priv();
        t_code_present();
        t_order();
        t_stack_kind();
        t_stack_priv();
        t_stack_present();
        t_vm86();
        t_hold();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule